// File: doc/BRIEF.md
# Huffman Tree Builder and Code Assigner

This block takes up to eight symbol weights and produces a prefix code for them. Each weight is a 16-bit count written to a per-symbol slot over a valid/ready port. A start pulse then launches a run. The block keeps the set of live tree nodes, merges the two lightest into a fresh parent node once per cycle, and records each merge in separate tables: leaf weights, leaf branch bits, internal node weights, internal node branch bits and parent links. When one node is left, that node is the root. A second phase then visits the nodes from the root downwards and derives each node's code from its parent's code.

The result is a per-symbol table of code bits and code length. It can be read at any time through a combinational index port, and a done flag marks when it is complete. Weights stay in their slots between runs, so a caller can change one symbol and start again. The weight port applies back-pressure: `wt_ready` drops while a run is in progress, and a word is taken only on a cycle where `wt_valid` and `wt_ready` are both high. A producer must hold its word until it is taken.

Top module: `huff_tree_coder`

## Requirements
- R1: A weight word (`wt_sym`, `wt_val`) is stored into the slot of that symbol on a cycle where `wt_valid` and `wt_ready` are both high. `wt_ready` is high when no run is in progress and `start` is low. Stored weights persist across runs.
- R2: A `start` pulse while idle or done launches a run. `done` goes low on the next cycle, stays low during the run, rises when the table is complete, and holds until the next accepted start. A `start` during a run has no effect.
- R3: During a run `wt_ready` is low, and weights offered on the port are not stored. The run's result and the following runs use the earlier weights.
- R4: A symbol whose weight is 0 takes no part in the tree. Its length reads 0 and its code reads 0.
- R5: Each merge step combines the two live nodes of lowest weight into a new node whose weight is their sum. Leaves are nodes 0 to 7 by symbol index, and internal nodes are numbered 8 upwards in the order they are created. Among equal weights, the lower node index counts as the lighter one.
- R6: At every branch, the heavier child carries bit 1 and the lighter child carries bit 0. When the two children weigh the same, the child with the lower node index (the one created earlier) carries 0.
- R7: A symbol's code is its branch bits read from the root down to its leaf. The code is right-aligned in the 8-bit `rd_code`, with the bit nearest the root most significant. `rd_len` (4 bits) gives the number of valid bits.
- R8: With exactly one nonzero weight, no merge happens, and that symbol gets the code 0 with length 1.
- R9: With no nonzero weight, a run still completes and every length and code reads 0.
- R10: After reset, `done` is low, `wt_ready` is high, all stored weights are 0, and every code table entry reads 0.
- R11: `rd_code`/`rd_len` reflect the entry selected by `rd_sym` in the same cycle. An accepted start clears the table before the new codes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_valid | input | 1 | Weight word offered |
| wt_ready | output | 1 | Block can take a weight word |
| wt_sym | input | 3 | Symbol slot of the offered weight |
| wt_val | input | 16 | Weight count |
| start | input | 1 | Pulse to launch a tree build |
| done | output | 1 | Code table complete |
| rd_sym | input | 3 | Symbol to read from the code table |
| rd_code | output | 8 | Right-aligned code bits of `rd_sym` |
| rd_len | output | 4 | Code length of `rd_sym` (0 = unused) |

## Verification
The hardest situation to reach is a tie between a leaf and an internal node of equal weight. This is where both the merge order and the branch-bit rule depend only on node index. A geometric weight set (1, 1, 2, 4, ... 64) produces that tie at every step and yields a full-depth chain of seven-bit codes, and it is checked against literal values. Random sweeps draw weights from a tiny range so that ties and zero weights are frequent, and each result is compared with an arithmetic model that builds the codes leaf-upwards. Rejection during a run is reached by offering a weight and a second start right after launch, then re-running without reloading.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUILD  = 2'd1,
    ST_ASSIGN = 2'd2,
    ST_DONE   = 2'd3
  } huff_st_e;
endpackage

// File: rtl/huff_min2.sv
// Picks the two live nodes of least weight; ties go to the lower index.
module huff_min2 #(
  parameter int NN  = 15,
  parameter int NWW = 19,
  parameter int IW  = 4
) (
  input  logic [NN-1:0][NWW-1:0] w,
  input  logic [NN-1:0]          act,
  output logic [IW-1:0]          lo,
  output logic [IW-1:0]          hi
);
  logic [NWW-1:0] bw1, bw2;
  logic           f1, f2;

  always_comb begin
    lo  = '0;
    bw1 = '0;
    f1  = 1'b0;
    for (int i = 0; i < NN; i++) begin
      if (act[i] && (!f1 || w[i] < bw1)) begin
        lo  = IW'(i);
        bw1 = w[i];
        f1  = 1'b1;
      end
    end
    hi  = '0;
    bw2 = '0;
    f2  = 1'b0;
    for (int i = 0; i < NN; i++) begin
      if (act[i] && IW'(i) != lo && (!f2 || w[i] < bw2)) begin
        hi  = IW'(i);
        bw2 = w[i];
        f2  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/huff_code_table.sv
// Per-node code and length storage with a parent lookup port and a symbol read port.
module huff_code_table #(
  parameter int NN   = 15,
  parameter int NSYM = 8,
  parameter int CW   = 8,
  parameter int LW   = 4,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_code,
  input  logic [LW-1:0] wr_len,
  input  logic [IW-1:0] pa_idx,
  output logic [CW-1:0] pa_code,
  output logic [LW-1:0] pa_len,
  input  logic [IW-1:0] rs_idx,
  output logic [CW-1:0] rs_code,
  output logic [LW-1:0] rs_len
);
  logic [CW-1:0] code_q [NN];
  logic [LW-1:0] len_q  [NN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NN; i++) begin
        code_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NN; i++) begin
        if (clr) begin
          code_q[i] <= '0;
          len_q[i]  <= '0;
        end else if (wr_en && wr_idx == IW'(i)) begin
          code_q[i] <= wr_code;
          len_q[i]  <= wr_len;
        end
      end
    end
  end

  assign pa_code = code_q[pa_idx];
  assign pa_len  = len_q[pa_idx];
  assign rs_code = code_q[rs_idx];
  assign rs_len  = len_q[rs_idx];

  AST_LEN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_len <= LW'(NSYM - 1)); // R7
endmodule

// File: rtl/huff_tree_coder.sv
module huff_tree_coder
  import huff_pkg::*;
#(
  parameter int NSYM = 8,
  parameter int WW   = 16,
  parameter int CW   = 8,
  parameter int LW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wt_valid,
  output logic                    wt_ready,
  input  logic [$clog2(NSYM)-1:0] wt_sym,
  input  logic [WW-1:0]           wt_val,
  input  logic                    start,
  output logic                    done,
  input  logic [$clog2(NSYM)-1:0] rd_sym,
  output logic [CW-1:0]           rd_code,
  output logic [LW-1:0]           rd_len
);
  localparam int NN  = 2 * NSYM - 1;
  localparam int NI  = NSYM - 1;
  localparam int SW  = $clog2(NSYM);
  localparam int IW  = $clog2(NN);
  localparam int NWW = WW + SW;

  huff_st_e       st;
  logic [WW-1:0]  lw   [NSYM];   // leaf weights
  logic [NSYM-1:0] lbit;         // leaf branch bits
  logic [NWW-1:0] nw   [NI];     // internal node weights
  logic [NI-1:0]  nbit;          // internal node branch bits
  logic [IW-1:0]  par  [NN];     // parent links
  logic [NN-1:0]  pv, act;
  logic [IW-1:0]  nn, cnt, root, wi;
  logic           rootv;

  logic [NN-1:0][NWW-1:0] allw;
  logic [NN-1:0]          allbit;
  logic [NSYM-1:0]        lact;
  logic [IW-1:0]          m_lo, m_hi, fl, cnt0;
  logic [NWW-1:0]         msum, lsum;
  logic                   go, is_root, tw_en;
  logic [CW-1:0]          pa_code, tw_code;
  logic [LW-1:0]          pa_len, tw_len;

  for (genvar g = 0; g < NSYM; g++) begin : g_leaf
    assign allw[g]   = NWW'(lw[g]);
    assign allbit[g] = lbit[g];
    assign lact[g]   = lw[g] != '0;
  end
  for (genvar g = 0; g < NI; g++) begin : g_node
    assign allw[NSYM+g]   = nw[g];
    assign allbit[NSYM+g] = nbit[g];
  end

  always_comb begin
    fl   = '0;
    lsum = '0;
    for (int i = NSYM - 1; i >= 0; i--) begin
      if (lact[i]) fl = IW'(i);
      lsum = lsum + NWW'(lw[i]);
    end
    cnt0 = IW'($countones(lact));
  end

  huff_min2 #(.NN(NN), .NWW(NWW), .IW(IW)) u_min2 (
    .w(allw), .act(act), .lo(m_lo), .hi(m_hi)
  );

  assign msum     = allw[m_lo] + allw[m_hi];
  assign go       = start && (st == ST_IDLE || st == ST_DONE);
  assign wt_ready = (st == ST_IDLE || st == ST_DONE) && !start;
  assign done     = st == ST_DONE;

  // Top-down walk: a node's parent always has a higher index, so it is already coded.
  assign is_root = rootv && wi == root;
  assign tw_en   = st == ST_ASSIGN && (is_root || pv[wi]);
  assign tw_code = is_root ? '0 : {pa_code[CW-2:0], allbit[wi]};
  assign tw_len  = is_root ? ((root < IW'(NSYM)) ? LW'(1) : '0) : pa_len + LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      act   <= '0;
      pv    <= '0;
      nn    <= '0;
      cnt   <= '0;
      root  <= '0;
      rootv <= 1'b0;
      wi    <= '0;
      lbit  <= '0;
      nbit  <= '0;
      for (int i = 0; i < NN; i++)   par[i] <= '0;
      for (int i = 0; i < NSYM; i++) lw[i]  <= '0;
      for (int i = 0; i < NI; i++)   nw[i]  <= '0;
    end else begin
      if (wt_valid && wt_ready) begin
        for (int i = 0; i < NSYM; i++)
          if (wt_sym == SW'(i)) lw[i] <= wt_val;
      end
      case (st)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            act   <= {{NI{1'b0}}, lact};
            pv    <= '0;
            nn    <= IW'(NSYM);
            cnt   <= cnt0;
            root  <= fl;
            rootv <= cnt0 != '0;
            wi    <= IW'(NN - 1);
            if (cnt0 >= IW'(2))      st <= ST_BUILD;
            else if (cnt0 == IW'(1)) st <= ST_ASSIGN;
            else                     st <= ST_DONE;
          end
        end
        ST_BUILD: begin
          for (int i = 0; i < NN; i++) begin
            if (IW'(i) == m_lo || IW'(i) == m_hi) begin
              act[i] <= 1'b0;
              pv[i]  <= 1'b1;
              par[i] <= nn;
            end
            if (IW'(i) == nn) act[i] <= 1'b1;
          end
          for (int i = 0; i < NSYM; i++) begin
            if (IW'(i) == m_lo)      lbit[i] <= 1'b0;
            else if (IW'(i) == m_hi) lbit[i] <= 1'b1;
          end
          for (int i = 0; i < NI; i++) begin
            if (IW'(NSYM + i) == m_lo)      nbit[i] <= 1'b0;
            else if (IW'(NSYM + i) == m_hi) nbit[i] <= 1'b1;
            if (IW'(NSYM + i) == nn)        nw[i]   <= msum;
          end
          nn   <= nn + IW'(1);
          root <= nn;
          cnt  <= cnt - IW'(1);
          if (cnt == IW'(2)) begin
            st <= ST_ASSIGN;
            wi <= IW'(NN - 1);
          end
        end
        ST_ASSIGN: begin
          if (wi == '0) st <= ST_DONE;
          else          wi <= wi - IW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  huff_code_table #(.NN(NN), .NSYM(NSYM), .CW(CW), .LW(LW), .IW(IW)) u_tab (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .wr_en(tw_en), .wr_idx(wi), .wr_code(tw_code), .wr_len(tw_len),
    .pa_idx(par[wi]), .pa_code(pa_code), .pa_len(pa_len),
    .rs_idx(IW'(rd_sym)), .rs_code(rd_code), .rs_len(rd_len)
  );

  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BUILD |-> act[m_lo] && act[m_hi] && m_lo != m_hi &&
      (allw[m_lo] < allw[m_hi] || (allw[m_lo] == allw[m_hi] && m_lo < m_hi))); // R5
  AST_MERGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BUILD |=> $countones(act) == $past($countones(act)) - 1); // R5
  AST_ROOT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ASSIGN && rootv && root >= IW'(NSYM)) |-> allw[root] == lsum); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(act) <= 1); // R2
  AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUILD || st == ST_ASSIGN) |=> $stable(lsum)); // R3
endmodule

// File: tb/tb_huff_tree_coder.sv
module tb_huff_tree_coder;
  localparam int NSYM = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wt_valid, wt_ready, start, done;
  logic [2:0]  wt_sym, rd_sym;
  logic [15:0] wt_val;
  logic [7:0]  rd_code;
  logic [3:0]  rd_len;

  huff_tree_coder dut (
    .clk(clk), .rst_n(rst_n), .wt_valid(wt_valid), .wt_ready(wt_ready),
    .wt_sym(wt_sym), .wt_val(wt_val), .start(start), .done(done),
    .rd_sym(rd_sym), .rd_code(rd_code), .rd_len(rd_len)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  int ew [NSYM];
  int exp_len [NSYM];
  int exp_code [NSYM];
  logic [31:0] lf = 32'h1357_9bdf;

  task automatic check(string req, string what, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Arithmetic model: merge lightest pair, then walk each leaf up to the root.
  task automatic model();
    int nw [2*NSYM-1];
    int par [2*NSYM-1];
    int bt [2*NSYM-1];
    bit ac [2*NSYM-1];
    int cnt, nn, a, b, node, len, code;
    cnt = 0;
    nn  = NSYM;
    for (int i = 0; i < 2*NSYM-1; i++) begin
      nw[i] = (i < NSYM) ? ew[i] : 0;
      ac[i] = (i < NSYM) && ew[i] > 0;
      par[i] = 0;
      bt[i] = 0;
      if (ac[i]) cnt++;
    end
    while (cnt > 1) begin
      a = -1;
      for (int i = 0; i < nn; i++) if (ac[i] && (a < 0 || nw[i] < nw[a])) a = i;
      b = -1;
      for (int i = 0; i < nn; i++) if (ac[i] && i != a && (b < 0 || nw[i] < nw[b])) b = i;
      nw[nn] = nw[a] + nw[b];
      par[a] = nn; par[b] = nn;
      bt[a] = 0; bt[b] = 1;
      ac[a] = 0; ac[b] = 0; ac[nn] = 1;
      nn++;
      cnt--;
    end
    for (int s = 0; s < NSYM; s++) begin
      exp_len[s] = 0;
      exp_code[s] = 0;
      if (ew[s] > 0) begin
        if (nn == NSYM) begin
          exp_len[s] = 1;
        end else begin
          node = s; len = 0; code = 0;
          while (node != nn - 1) begin
            code = code | (bt[node] << len);
            len++;
            node = par[node];
          end
          exp_len[s] = len;
          exp_code[s] = code;
        end
      end
    end
  endtask

  task automatic wr(int s, int v);
    @(negedge clk);
    wt_valid = 1'b1;
    wt_sym = 3'(s);
    wt_val = 16'(v);
    @(negedge clk);
    wt_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int s = 0; s < NSYM; s++) wr(s, ew[s]);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int k;
    k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    check(req, "done", int'(done), 1);
  endtask

  task automatic check_table(string req);
    model();
    for (int s = 0; s < NSYM; s++) begin
      rd_sym = 3'(s);
      #1;
      check(req, $sformatf("len sym%0d", s), int'(rd_len), exp_len[s]);
      check(req, $sformatf("code sym%0d", s), int'(rd_code), exp_code[s]);
    end
  endtask

  task automatic run(string req);
    load_all();
    pulse_start();
    wait_done(req);
    check_table(req);
  endtask

  initial begin
    rst_n = 1'b0; wt_valid = 1'b0; wt_sym = '0; wt_val = '0; start = 1'b0; rd_sym = '0;
    for (int s = 0; s < NSYM; s++) ew[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "done", int'(done), 0);
    check("R10", "wt_ready", int'(wt_ready), 1);
    check_table("R10");

    // R9: no weights at all
    pulse_start();
    wait_done("R9");
    check_table("R9");

    // R8 / R4: single symbol, rest zero
    ew[5] = 42;
    run("R8");
    rd_sym = 3'd5; #1;
    check("R8", "len sym5 literal", int'(rd_len), 1);
    check("R4", "len sym0 zero weight", 0, 0 + int'(exp_len[0]));

    // R6: two equal weights, lower index gets 0
    for (int s = 0; s < NSYM; s++) ew[s] = 0;
    ew[2] = 7; ew[6] = 7;
    run("R6");
    rd_sym = 3'd2; #1; check("R6", "code sym2 literal", int'(rd_code), 0);
    rd_sym = 3'd6; #1; check("R6", "code sym6 literal", int'(rd_code), 1);

    // R7: eight equal weights give code == symbol index, length 3
    for (int s = 0; s < NSYM; s++) ew[s] = 10;
    run("R7");
    for (int s = 0; s < NSYM; s++) begin
      rd_sym = 3'(s); #1;
      check("R7", "flat code literal", int'(rd_code), s);
      check("R7", "flat len literal", int'(rd_len), 3);
    end

    // R5 / R6: geometric weights, leaf-vs-internal ties at each step
    ew[0] = 1; ew[1] = 1; ew[2] = 2; ew[3] = 4; ew[4] = 8; ew[5] = 16; ew[6] = 32; ew[7] = 64;
    run("R5");
    rd_sym = 3'd0; #1; check("R5", "chain code sym0", int'(rd_code), 126);
    check("R5", "chain len sym0", int'(rd_len), 7);
    rd_sym = 3'd1; #1; check("R6", "chain code sym1", int'(rd_code), 127);
    rd_sym = 3'd6; #1; check("R6", "chain code sym6", int'(rd_code), 2);
    rd_sym = 3'd7; #1; check("R7", "chain len sym7", int'(rd_len), 1);

    // R4 / R1: clear one slot only; others retained
    ew[3] = 0;
    wr(3, 0);
    pulse_start();
    wait_done("R1");
    check_table("R4");

    // R3 / R2: offers and a second start during a run are ignored
    for (int s = 0; s < NSYM; s++) ew[s] = 3 + s;
    load_all();
    pulse_start();
    check("R3", "wt_ready busy", int'(wt_ready), 0);
    check("R2", "done busy", int'(done), 0);
    wt_valid = 1'b1; wt_sym = 3'd0; wt_val = 16'd999; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    wt_valid = 1'b0;
    wait_done("R2");
    check_table("R3");
    pulse_start();
    wait_done("R3");
    check_table("R3");

    // R11: table cleared by start before being rewritten
    for (int s = 0; s < NSYM; s++) ew[s] = 0;
    ew[1] = 5;
    load_all();
    pulse_start();
    rd_sym = 3'd4; #1;
    check("R11", "cleared at start", int'(rd_len), 0);
    wait_done("R11");
    check_table("R11");

    // R1 / R5: full-range weights
    for (int s = 0; s < NSYM; s++) ew[s] = 65535 - s;
    run("R1");

    // Sweep: tiny-range weights (ties, zeros) and wide-range weights
    for (int k = 0; k < 48; k++) begin
      for (int s = 0; s < NSYM; s++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (k % 2 == 0) ew[s] = int'(lf[2:0]);
        else            ew[s] = int'(lf[15:0]) >> int'(lf[19:16]);
      end
      run((k % 2 == 0) ? "R6" : "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule